// File: doc/BRIEF.md
# Factory Bad-Block Scanner

This block builds a map of the blocks that were marked defective at the factory in one NAND die. It runs once after power-up initialisation. The system pulses `start`, and the scanner then asks the lower-level NAND sequencer to issue the reset command. After that it reads one byte from every block in turn, at the first spare-area column of page 0. Erased parts read FFh there, so any other value means the block carries a factory defect mark. Block 0 is always recorded as usable.

The result is a 4096-entry bitmap with one bit per block. Before issuing a program or erase, a host queries the bitmap through a registered lookup port. Until the scan has finished, every lookup answers "bad", so an early program or erase is refused. When the scan ends, `busy` drops, `done` rises and stays high, and `bad_count` holds the number of defective blocks found.

The controller is a four-state machine:
- IDLE moves to RESET_CMD on `start`.
- RESET_CMD holds the reset request. It moves to READ_MARK when the sequencer responds.
- READ_MARK requests one block at a time. It records the block on each response and moves to DONE after the response for the last block.
- DONE is terminal until `rst_n` is asserted.

Top module: `badblk_scan`

## Requirements
- R1: A `start` pulse in IDLE makes `busy` rise on the next cycle. The first request presented has `req_is_reset`=1, which stands for the FFh reset command. No read request appears until that request has received its `rsp_valid`.
- R2: Every read request carries `req_page`=0 and `req_col`=2048. It holds `req_valid`, `req_block` and `req_is_reset` steady until the cycle in which `rsp_valid` is seen.
- R3: Read requests cover blocks 0 to 4095 exactly once each, in ascending order.
- R4: A returned byte of FFh records the block as good (bitmap bit 0). Any other value records it as bad (bitmap bit 1).
- R5: Block 0 is recorded as good whatever byte is returned for it.
- R6: A lookup with `lk_en`=1 updates `lk_bad` on the following clock edge. If `done` is low at the lookup edge, the answer is 1 (bad) regardless of the block.
- R7: After the response for block 4095, `busy` falls and `done` rises on the same edge. `busy` and `done` are never high together. `done` stays high until reset, and a later `start` issues no further requests.
- R8: Once `done` is high, `bad_count` equals the number of blocks recorded as bad and does not change.
- R9: During reset, `busy`=0, `done`=0, `req_valid`=0, `bad_count`=0 and `lk_bad`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin the scan after power-up initialisation |
| req_valid | output | 1 | Request to the NAND sequencer is pending |
| req_is_reset | output | 1 | 1: reset command (FFh); 0: single-byte page read |
| req_block | output | 12 | Block address of the read |
| req_page | output | 6 | Page within block (always 0) |
| req_col | output | 12 | Byte column (always 2048, first spare byte) |
| rsp_valid | input | 1 | One-cycle completion of the pending request |
| rsp_data | input | 8 | Byte returned for a read request |
| lk_en | input | 1 | Lookup strobe |
| lk_block | input | 12 | Block to look up |
| lk_bad | output | 1 | Registered lookup result, 1 = bad or scan not finished |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete and bitmap valid |
| bad_count | output | 13 | Number of blocks recorded as bad |

## Verification
The assertions assume that the sequencer raises `rsp_valid` only for one cycle, only while a request is pending, and never twice for the same request. They also assume that `start` is a single-cycle pulse. The bench sequencer model keeps to this contract. It answers each pending request once, after a random delay of zero to two cycles, and clears `rsp_valid` on the next cycle. Lookups are driven at any time, both during and after the scan, because the port places no condition on them.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RESET_CMD = 2'd1,
        ST_READ_MARK = 2'd2,
        ST_DONE      = 2'd3
    } scan_state_t;
endpackage

// File: rtl/bbs_fsm.sv
module bbs_fsm
    import bbs_pkg::*;
#(
    parameter int          NUM_BLOCKS = 4096,
    parameter int          BLK_W      = $clog2(NUM_BLOCKS),
    parameter logic [7:0]  GOOD_MARK  = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_data,
    output logic             req_valid,
    output logic             req_is_reset,
    output logic [BLK_W-1:0] req_block,
    output logic             wr_en,
    output logic [BLK_W-1:0] wr_block,
    output logic             wr_bad,
    output logic             busy,
    output logic             done
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_state_t      state_q, state_d;
    logic [BLK_W-1:0] idx_q, idx_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_RESET_CMD;
            end
            ST_RESET_CMD: begin
                if (rsp_valid) begin
                    state_d = ST_READ_MARK;
                    idx_d   = '0;
                end
            end
            ST_READ_MARK: begin
                if (rsp_valid) begin
                    if (idx_q == LAST_BLK) state_d = ST_DONE;
                    else                   idx_d   = idx_q + 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        req_valid    = 1'b0;
        req_is_reset = 1'b0;
        busy         = 1'b0;
        done         = 1'b0;
        wr_en        = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESET_CMD: begin
                req_valid    = 1'b1;
                req_is_reset = 1'b1;
                busy         = 1'b1;
            end
            ST_READ_MARK: begin
                req_valid = 1'b1;
                busy      = 1'b1;
                wr_en     = rsp_valid;
            end
            ST_DONE: done = 1'b1;
        endcase
        req_block = idx_q;
        wr_block  = idx_q;
        wr_bad    = (idx_q != '0) && (rsp_data != GOOD_MARK);
    end
endmodule

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic          map_valid,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bad
);
    logic [DEPTH-1:0] map_q;

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else if (wr_en) map_q[wr_addr] <= wr_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_bad <= 1'b1;
        else if (rd_en) rd_bad <= !map_valid || map_q[rd_addr];
    end
endmodule

// File: rtl/bbs_tally.sv
module bbs_tally #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/badblk_scan.sv
module badblk_scan #(
    parameter int         NUM_BLOCKS = 4096,
    parameter int         PAGE_W     = 6,
    parameter int         COL_W      = 12,
    parameter int         SPARE_COL  = 2048,
    parameter logic [7:0] GOOD_MARK  = 8'hFF,
    parameter int         BLK_W      = $clog2(NUM_BLOCKS),
    parameter int         CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              req_valid,
    output logic              req_is_reset,
    output logic [BLK_W-1:0]  req_block,
    output logic [PAGE_W-1:0] req_page,
    output logic [COL_W-1:0]  req_col,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    input  logic              lk_en,
    input  logic [BLK_W-1:0]  lk_block,
    output logic              lk_bad,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  bad_count
);
    logic             wr_en;
    logic [BLK_W-1:0] wr_block;
    logic             wr_bad;

    assign req_page = '0;
    assign req_col  = COL_W'(SPARE_COL);

    bbs_fsm #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_W     (BLK_W),
        .GOOD_MARK (GOOD_MARK)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .req_valid   (req_valid),
        .req_is_reset(req_is_reset),
        .req_block   (req_block),
        .wr_en       (wr_en),
        .wr_block    (wr_block),
        .wr_bad      (wr_bad),
        .busy        (busy),
        .done        (done)
    );

    bbs_bitmap #(
        .DEPTH(NUM_BLOCKS),
        .AW   (BLK_W)
    ) map_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_block),
        .wr_bit   (wr_bad),
        .map_valid(done),
        .rd_en    (lk_en),
        .rd_addr  (lk_block),
        .rd_bad   (lk_bad)
    );

    bbs_tally #(
        .CNT_W(CNT_W)
    ) tally_i (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (wr_en && wr_bad),
        .count(bad_count)
    );
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
    parameter int NUM_BLOCKS = 4096,
    parameter int BLK_W      = 12,
    parameter int CNT_W      = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             req_valid,
    input logic             req_is_reset,
    input logic [BLK_W-1:0] req_block,
    input logic             rsp_valid,
    input logic             lk_en,
    input logic [BLK_W-1:0] lk_block,
    input logic             lk_bad,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] bad_count
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    assert_start_reset_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !done |=> busy && req_valid && req_is_reset);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !rsp_valid |=> req_valid && $stable(req_block) && $stable(req_is_reset));

    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_is_reset && rsp_valid && req_block != LAST_BLK
        |=> req_valid && req_block == $past(req_block) + 1'b1);

    assert_block0_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en && done && lk_block == '0 |=> !lk_bad);

    assert_early_lookup_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en && !done |=> lk_bad);

    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !req_valid);

    assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(bad_count));
endmodule

bind badblk_scan bbs_checker #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_W     (BLK_W),
    .CNT_W     (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_valid   (req_valid),
    .req_is_reset(req_is_reset),
    .req_block   (req_block),
    .rsp_valid   (rsp_valid),
    .lk_en       (lk_en),
    .lk_block    (lk_block),
    .lk_bad      (lk_bad),
    .busy        (busy),
    .done        (done),
    .bad_count   (bad_count)
);

// File: tb/badblk_scan_tb_top.sv
module badblk_scan_tb_top;
    localparam int CLK_P = 10;
    localparam int NB    = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_valid, req_is_reset;
    logic [11:0] req_block;
    logic [5:0]  req_page;
    logic [11:0] req_col;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = 8'h00;
    logic        lk_en = 1'b0;
    logic [11:0] lk_block = '0;
    logic        lk_bad, busy, done;
    logic [12:0] bad_count;

    int checks = 0;
    int fails  = 0;

    logic [7:0] marks [NB];

    // sequencer model bookkeeping
    int  reset_seen = 0, order_err = 0, addr_err = 0, hold_err = 0, reads_seen = 0;
    int  next_blk = 0;
    int  wait_cnt = 0;
    bit  pend = 0;
    logic [11:0] pend_blk;
    logic        pend_rst;

    always #(CLK_P/2) clk = ~clk;

    badblk_scan dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_is_reset(req_is_reset), .req_block(req_block),
        .req_page(req_page), .req_col(req_col),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .lk_en(lk_en), .lk_block(lk_block), .lk_bad(lk_bad),
        .busy(busy), .done(done), .bad_count(bad_count)
    );

    function automatic bit exp_bad(input int b);
        return (b != 0) && (marks[b] != 8'hFF);
    endfunction

    function automatic int exp_count();
        int n = 0;
        for (int i = 0; i < NB; i++) if (exp_bad(i)) n++;
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sequencer model: answers each pending request once after 0..2 cycles
    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (rst_n && req_valid) begin
            if (!pend) begin
                pend     = 1'b1;
                wait_cnt = $urandom_range(0, 2);
                pend_blk = req_block;
                pend_rst = req_is_reset;
            end else begin
                if (req_block != pend_blk || req_is_reset != pend_rst) hold_err++;
                if (wait_cnt == 0) begin
                    pend = 1'b0;
                    if (req_is_reset) begin
                        if (reset_seen != 0 || reads_seen != 0) order_err++;
                        reset_seen++;
                        rsp_data = 8'h00;
                    end else begin
                        if (reset_seen != 1) order_err++;
                        if (int'(req_block) != next_blk) order_err++;
                        if (req_page != 6'd0 || req_col != 12'd2048) addr_err++;
                        next_blk++;
                        reads_seen++;
                        rsp_data = marks[req_block];
                    end
                    rsp_valid = 1'b1;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_P * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NB; i++) begin
            if ($urandom_range(0, 7) == 0) marks[i] = 8'($urandom_range(0, 254));
            else                           marks[i] = 8'hFF;
        end
        // directed corners
        marks[0]    = 8'h00;   // block 0 forced good (R5)
        marks[1]    = 8'hFE;   // one bit off (R4)
        marks[2]    = 8'hFF;
        marks[3]    = 8'h7F;
        marks[4095] = 8'h00;   // last block bad

        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy == 1'b0, "R9 busy", busy, 0);
        chk(done == 1'b0, "R9 done", done, 0);
        chk(req_valid == 1'b0, "R9 req_valid", req_valid, 0);
        chk(bad_count == 13'd0, "R9 bad_count", bad_count, 0);
        chk(lk_bad == 1'b1, "R9 lk_bad", lk_bad, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // lookup before scan (R6)
        lk_en = 1'b1; lk_block = 12'd2;
        @(negedge clk);
        lk_en = 1'b0;
        chk(lk_bad == 1'b1, "R6 lookup before start", lk_bad, 1);

        // R1 start
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        chk(req_valid && req_is_reset, "R1 first request is reset", req_is_reset, 1);

        // random lookups during the scan must answer bad (R6)
        for (int k = 0; k < 40; k++) begin
            bit was_done;
            repeat ($urandom_range(1, 30)) @(negedge clk);
            was_done = done;
            lk_en = 1'b1; lk_block = 12'($urandom_range(0, NB - 1));
            @(negedge clk);
            lk_en = 1'b0;
            if (!was_done) chk(lk_bad == 1'b1, "R6 lookup during scan", lk_bad, 1);
        end

        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R7 busy low at done", busy, 0);
        chk(reset_seen == 1, "R1 reset issued once", reset_seen, 1);
        chk(order_err == 0, "R3 order errors", order_err, 0);
        chk(reads_seen == NB, "R3 read count", reads_seen, NB);
        chk(addr_err == 0, "R2 page/column errors", addr_err, 0);
        chk(hold_err == 0, "R2 request hold errors", hold_err, 0);
        chk(int'(bad_count) == exp_count(), "R8 bad_count", bad_count, exp_count());

        // full bitmap readback (R4, R5)
        for (int b = 0; b < NB; b++) begin
            lk_en = 1'b1; lk_block = 12'(b);
            @(negedge clk);
            chk(lk_bad == exp_bad(b), (b == 0) ? "R5 block 0 lookup" : "R4 bitmap lookup",
                lk_bad, exp_bad(b));
        end
        lk_en = 1'b0;

        // lk_bad holds when lk_en low (R6)
        lk_block = 12'd1;
        @(negedge clk);
        chk(lk_bad == exp_bad(NB - 1), "R6 lookup holds without strobe", lk_bad, exp_bad(NB - 1));

        // late start ignored (R7), count frozen (R8)
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R7 done sticky after late start", done, 1);
        chk(reads_seen == NB && reset_seen == 1, "R7 no requests after done", reads_seen, NB);
        chk(int'(bad_count) == exp_count(), "R8 bad_count frozen", bad_count, exp_count());

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule